// File: doc/BRIEF.md
# Double-Buffered Color Palette

This block is a 256-entry color lookup table for a display output path. It holds two palette banks. One bank is active and turns each 8-bit pixel index into an 18-bit color word for the DAC pins. The other bank is shadow storage that the host can load through a small register port. Because the host never writes the bank being displayed, loading a palette causes no visible glitch.

When a palette is ready, the host sets a swap-request bit. The request stays pending until the next rising edge of the blank input, which marks the start of the blanking interval. At that edge the banks trade roles, and the pending flag clears by itself. A status word shows the active bank and the pending flag. The host can read either bank back to verify its contents.

Each host access is one cycle, so a write never splits across banks. A write that happens in the same cycle as a swap goes to the bank that was shadow before that edge, and so it is shown from then on.

Top module: `palette_lut`

## Requirements
- R1: After reset, bank 0 is active, no swap is pending, the status reads 0, and every entry of both banks reads 0.
- R2: A host write with address bit 9 = 0 stores the 24-bit data word (red 23:16, green 15:8, blue 7:0) at entry address[7:0] of the bank that is not active. Address bit 8 has no effect on where a write goes.
- R3: The pixel output shows the active bank's entry for the index sampled at the previous clock edge. Output bits 17:12 are red[7:2], bits 11:6 are green[7:2], and bits 5:0 are blue[7:2].
- R4: If blank is high at a clock edge, the pixel output after that edge is zero.
- R5: A host write to address bit 9 = 1 with data bit 0 = 1 sets the pending flag. The flag stays set while blank shows no rising edge. The status word has the active bank in bit 0 and the pending flag in bit 1.
- R6: A swap happens only at a clock edge where blank is high, blank was low at the previous edge, and a request is pending. The swap toggles the active bank and clears the pending flag. A blank interval that lasts many cycles causes only one swap.
- R7: A second request made while one is pending merges with it. Only one swap follows.
- R8: A palette write in the same cycle as a swap lands whole in the bank that was inactive before that edge, which is the newly active bank. The other bank is left unchanged.
- R9: A control write with data bit 0 = 0 does not change the pending flag or the active bank.
- R10: A host read returns data one clock after it is issued. With address bit 9 = 0 it returns entry address[7:0] of bank address[8]. With address bit 9 = 1 it returns the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the pixel path |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_rd | input | 1 | Host read strobe for one cycle |
| host_addr | input | 10 | Bit 9 selects the control/status word; bit 8 selects the bank for reads; bits 7:0 select the entry |
| host_wdata | input | 24 | Write data: a palette entry, or bit 0 as the swap request |
| host_rdata | output | 24 | Read data, valid one cycle after host_rd |
| blank | input | 1 | Blanking indicator from the raster timing logic |
| pix_idx | input | 8 | Pixel index |
| pix_rgb | output | 18 | Packed color for the DAC |

## Verification
The assertions check on every cycle the rules about when the active bank may change: only after a blank rising edge with a request pending, never without a pending request, and with the pending flag cleared by the swap. They also check that blank forces the pixel output to zero, and that a pending flag survives any cycle without blank. The bench scenarios show the things a property cannot see: table contents landing in the correct bank, the bit packing of each color, request merging across a frame, and the ordering of a palette write that coincides with a swap.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int IDX_W  = 8;
    localparam int CH_W   = 8;
    localparam int DAC_W  = 6;
    localparam int ENT_W  = 3 * CH_W;
    localparam int OUT_W  = 3 * DAC_W;
    localparam int ADDR_W = IDX_W + 2;
    localparam int NBANK  = 2;

    typedef logic [ENT_W-1:0] entry_t;
    typedef logic [OUT_W-1:0] dac_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic ctrl;
        logic bank;
        idx_t idx;
    } haddr_t;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } color_t;

    function automatic dac_t pack_color(input entry_t e);
        color_t c;
        c = color_t'(e);
        return {c.red[CH_W-1 -: DAC_W], c.green[CH_W-1 -: DAC_W], c.blue[CH_W-1 -: DAC_W]};
    endfunction
endpackage

// File: rtl/pal_bank.sv
module pal_bank
    import pal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  idx_t   waddr,
    input  entry_t wdata,
    input  idx_t   haddr,
    output entry_t hdata,
    input  idx_t   paddr,
    output entry_t pdata
);
    localparam int DEPTH = 1 << IDX_W;

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign hdata = mem[haddr];
    assign pdata = mem[paddr];
endmodule

// File: rtl/pal_swap_ctrl.sv
module pal_swap_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic blank,
    output logic act,
    output logic pend
);
    logic blank_q;
    logic rise;

    assign rise = blank && !blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b1;
            act     <= 1'b0;
            pend    <= 1'b0;
        end else begin
            blank_q <= blank;
            if (rise && pend) act <= ~act;
            if (req)       pend <= 1'b1;
            else if (rise) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pal_pixel_out.sv
module pal_pixel_out
    import pal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   blank,
    input  entry_t ent,
    output dac_t   pix
);
    always_ff @(posedge clk) begin
        if (rst || blank) pix <= '0;
        else              pix <= pack_color(ent);
    end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ENT_W-1:0]  host_wdata,
    output logic [ENT_W-1:0]  host_rdata,
    input  logic              blank,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [OUT_W-1:0]  pix_rgb
);
    haddr_t ha;
    logic   act_bank;
    logic   swap_pend;
    logic   swap_req;
    entry_t h_rd [NBANK];
    entry_t p_rd [NBANK];

    assign ha       = haddr_t'(host_addr);
    assign swap_req = host_wr && ha.ctrl && host_wdata[0];

    pal_swap_ctrl u_swap (
        .clk(clk), .rst(rst), .req(swap_req), .blank(blank),
        .act(act_bank), .pend(swap_pend)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic we_b;
        assign we_b = host_wr && !ha.ctrl && (act_bank != b[0]);
        pal_bank u_bank (
            .clk(clk), .rst(rst), .we(we_b), .waddr(ha.idx), .wdata(host_wdata),
            .haddr(ha.idx), .hdata(h_rd[b]), .paddr(pix_idx), .pdata(p_rd[b])
        );
    end

    pal_pixel_out u_pix (
        .clk(clk), .rst(rst), .blank(blank), .ent(p_rd[act_bank]), .pix(pix_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (ha.ctrl) host_rdata <= {{(ENT_W-2){1'b0}}, swap_pend, act_bank};
            else         host_rdata <= h_rd[ha.bank];
        end
    end
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
    import pal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       blank,
    input logic       act,
    input logic       pend,
    input logic       req,
    input logic [OUT_W-1:0] pix
);
    AST_SWAP_NEEDS_PEND_BLANK: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> ($past(pend) && $past(blank))) else $error("swap without cause"); // R6
    AST_SWAP_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act) && !$past(req)) |-> !pend) else $error("pending kept after swap"); // R6
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(blank) |-> (pix == '0)) else $error("pixel during blank"); // R4
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pend && !blank) |=> pend) else $error("pending lost"); // R5
    AST_NO_SWAP_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        ($past(blank) && blank) |=> $stable(act)) else $error("second swap in blank"); // R6
endmodule

bind palette_lut palette_lut_chk u_chk (
    .clk(clk), .rst(rst), .blank(blank), .act(act_bank), .pend(swap_pend),
    .req(swap_req), .pix(pix_rgb)
);

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        host_wr = 0, host_rd = 0;
    logic [9:0]  host_addr = '0;
    logic [23:0] host_wdata = '0;
    logic [23:0] host_rdata;
    logic        blank = 0;
    logic [7:0]  pix_idx = '0;
    logic [17:0] pix_rgb;
    int n_run = 0, n_fail = 0;
    logic [23:0] rd;

    always #2 clk = ~clk;

    palette_lut u_palette_lut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .blank(blank), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    localparam logic [31:0] VEC [8] = '{
        {8'h00, 24'hFFFFFF}, {8'h01, 24'h800000}, {8'h7F, 24'h00FC00},
        {8'h80, 24'h0000FC}, {8'hFE, 24'h123456}, {8'hFF, 24'hA5C3E1},
        {8'h3C, 24'h030303}, {8'hA5, 24'hFC0004}
    };

    function automatic logic [17:0] exp_pix(input logic [23:0] c);
        return {c[23:18], c[15:10], c[7:2]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [9:0] a, input logic [23:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input logic [9:0] a, output logic [23:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic blank_pulse(input int n);
        @(negedge clk);
        blank = 1;
        repeat (n) @(negedge clk);
        blank = 0;
        @(negedge clk);
    endtask

    task automatic lookup(input logic [7:0] i, output logic [17:0] p);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        p = pix_rgb;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [17:0] p;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        hread(10'h200, rd); check("R1 status", rd, 0);
        hread(10'h0FF, rd); check("R1 bank0", rd, 0);
        hread(10'h1FF, rd); check("R1 bank1", rd, 0);
        // R2 load shadow bank (bank 1) from table; bit 8 set on some writes
        for (int k = 0; k < 8; k++) hwrite({1'b0, k[0], VEC[k][31:24]}, VEC[k][23:0]);
        for (int k = 0; k < 8; k++) begin
            hread({2'b01, VEC[k][31:24]}, rd); check("R2 R10 bank1", rd, {8'h0, VEC[k][23:0]});
            hread({2'b00, VEC[k][31:24]}, rd); check("R2 bank0 untouched", rd, 0);
        end
        lookup(8'h00, p); check("R3 active bank0", p, 0);
        // R5 request and hold
        hwrite(10'h200, 24'h1);
        hread(10'h200, rd); check("R5 pending", rd, 2);
        repeat (20) @(negedge clk);
        hread(10'h200, rd); check("R5 still pending", rd, 2);
        // R9 zero request is ignored
        hwrite(10'h200, 24'hFFFFFE);
        hread(10'h200, rd); check("R9 no effect", rd, 2);
        // R7 merged request
        hwrite(10'h200, 24'h1);
        blank_pulse(3);
        hread(10'h200, rd); check("R6 R7 swapped", rd, 1);
        blank_pulse(3);
        hread(10'h200, rd); check("R7 single swap", rd, 1);
        // R3 pixel path with bank 1 active
        for (int k = 0; k < 8; k++) begin
            lookup(VEC[k][31:24], p); check("R3 lookup", p, exp_pix(VEC[k][23:0]));
        end
        // R4 blank forces zero
        @(negedge clk); pix_idx = 8'h00; blank = 1;
        @(negedge clk); check("R4 blank zero", pix_rgb, 0);
        blank = 0;
        @(negedge clk); @(negedge clk); check("R4 after blank", pix_rgb, exp_pix(24'hFFFFFF));
        // R6 long blank gives one swap
        hwrite(10'h200, 24'h1);
        blank_pulse(12);
        hread(10'h200, rd); check("R6 long blank", rd, 0);
        // R8 write racing a swap: active is bank 0, shadow is bank 1
        hwrite(10'h200, 24'h1);
        @(negedge clk);
        blank = 1; host_wr = 1; host_addr = 10'h055; host_wdata = 24'h5A5A5A;
        @(negedge clk);
        host_wr = 0; blank = 0;
        hread(10'h200, rd); check("R8 swap done", rd, 1);
        hread(10'h155, rd); check("R8 landed bank1", rd, 24'h5A5A5A);
        hread(10'h055, rd); check("R8 bank0 untouched", rd, 0);
        lookup(8'h55, p); check("R8 visible", p, exp_pix(24'h5A5A5A));
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule